// File: doc/BRIEF.md
# Nibble-Field Prioritized Interrupt Controller

This block gathers 28 interrupt sources and reports, every cycle, the highest priority level among the sources that are requesting service, together with the number of the source that holds it. Each source owns a 4-bit field in one of four 32-bit control registers. The low three bits of a field are its priority level, and level 0 masks the source. The top bit of the field qualifies a write, so a single 32-bit store can change any subset of sources and leave the rest alone.

Six of the sources are external pins. Each pin is synchronised and then edge-detected with a selectable polarity. A detected edge is held in a pending latch until software clears it. Software clears it by writing the source's field with the qualify bit set. Because of this, the same store that masks an external source (field value 0x8) also discards its pending edge. The other 22 sources are level inputs and request service for as long as they are high.

A processor-side interrupt unit reads the level and source number. It uses the control registers to mask, enable and acknowledge sources.

Top module: `nibint_ctrl`

## Requirements
- R1: After reset every priority is 0, every pending latch is clear, `irq_level` and `irq_src` are 0, the polarity register reads 0x3F (all rising), and every control register reads 0 while all inputs are low.
- R2: Source k lives in control register k/8 (address 0 to 3), in bits [31-4*(k%8) -: 4]. Bits 2:0 of that nibble are its priority. The four nibbles after source 27 (address 3, bits 15:0) always read 0 and ignore writes.
- R3: A write changes a field only when that field's bit 3 is written as 1. A field whose bit 3 is written as 0 keeps its priority.
- R4: A source whose priority is 0 never drives `irq_level` or `irq_src`, even while its input is active.
- R5: Sources 0, 1, 2, 3, 25 and 26 are edge-triggered. A detected edge sets a pending latch, which holds after the pin returns. Bit 3 of such a field reads the latch. For every other source, bit 3 reads the current input level.
- R6: Address 4 is the polarity register. Bit j belongs to the j-th edge source in the order 0, 1, 2, 3, 25, 26. Value 1 selects rising edges and 0 selects falling edges.
- R7: A write with bit 3 set clears that source's pending latch and loads bits 2:0 as its priority. Thus 0x8 masks and acknowledges, and rewriting the same priority with bit 3 set only acknowledges.
- R8: An edge detected in the same cycle as an acknowledge write leaves the pending latch set.
- R9: `irq_level` is the highest priority among active, unmasked sources, and `irq_src` is that source. Ties go to the lower source number. Both outputs are 0 when nothing requests, and both are registered, so they change one clock after the request state changes.
- R10: A level source stops requesting as soon as its input falls, with no acknowledge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address (0-3 control, 4 polarity) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| src_in | input | 28 | Interrupt source inputs, index = source number |
| irq_level | output | 3 | Highest requesting priority, 0 when idle |
| irq_src | output | 5 | Source number of the winning request |

## Verification
An edge on an external pin and a software acknowledge of the same source can land in one clock, and only the edge may survive. The bench provokes this by raising source 26 and counting exactly two clocks through the synchroniser. It then presents the acknowledge write in the cycle where the edge is detected. The collision is judged correct when bit 3 of the field still reads 1 afterwards and the output reports source 26 at its new level. A separate acknowledge without an edge must clear the latch.

// File: rtl/nibint_pkg.sv
package nibint_pkg;
  localparam int NUM_SRC  = 28;
  localparam int FIELDS   = 8;
  localparam int REGS     = 4;
  localparam int PRIO_W   = 3;
  localparam int FIELD_W  = PRIO_W + 1;
  localparam int DATA_W   = FIELDS * FIELD_W;
  localparam int ADDR_W   = 3;
  localparam int POL_ADDR = REGS;
  localparam int SRC_W    = $clog2(NUM_SRC);
  localparam logic [NUM_SRC-1:0] EDGE_MASK = 28'h600000F;

  // number of set bits of m below position k
  function automatic int ext_rank(input logic [31:0] m, input int k);
    int n;
    n = 0;
    for (int i = 0; i < k; i++) begin
      if (m[i]) n++;
    end
    return n;
  endfunction

  function automatic int ext_count(input logic [31:0] m);
    return ext_rank(m, 32);
  endfunction

  localparam int NUM_EXT = ext_count(32'(EDGE_MASK));
endpackage

// File: rtl/nibint_edge.sv
module nibint_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic rise_sel_i,
  input  logic ack_i,
  output logic pending_o
);
  logic sync1_q, sync2_q, prev_q, pend_q;
  logic sync1_d, sync2_d, prev_d, pend_d;
  logic edge_hit, pend_en;

  always_comb begin
    sync1_d  = raw_i;
    sync2_d  = sync1_q;
    prev_d   = sync2_q;
    edge_hit = rise_sel_i ? (sync2_q & ~prev_q) : (~sync2_q & prev_q);
    pend_en  = edge_hit | ack_i;
    pend_d   = edge_hit;   // edge beats a simultaneous acknowledge
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      sync1_q <= sync1_d;
      sync2_q <= sync2_d;
      prev_q  <= prev_d;
      if (pend_en) pend_q <= pend_d;
    end
  end

  assign pending_o = pend_q;

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !edge_hit) |=> !pending_o);
  assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> pending_o);
  assert_pending_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_i && !edge_hit) |=> $stable(pending_o));
endmodule

// File: rtl/nibint_regs.sv
module nibint_regs
  import nibint_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int N_EXT = NUM_EXT
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [N_SRC-1:0][PRIO_W-1:0]  prio_o,
  output logic [N_SRC-1:0]              ack_o,
  output logic [N_EXT-1:0]              pol_o
);
  logic [N_SRC-1:0][PRIO_W-1:0] prio_q, prio_d;
  logic [N_EXT-1:0]             pol_q, pol_d;
  logic                         pol_wr;

  for (genvar k = 0; k < N_SRC; k++) begin : g_field
    localparam int RI  = k / FIELDS;
    localparam int FI  = k % FIELDS;
    localparam int TOP = DATA_W - 1 - FIELD_W * FI;

    assign ack_o[k] = wr_en && (addr == ADDR_W'(RI)) && wdata[TOP];

    always_comb begin
      prio_d[k] = ack_o[k] ? wdata[TOP-1 -: PRIO_W] : prio_q[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        prio_q[k] <= '0;
      else if (ack_o[k]) prio_q[k] <= prio_d[k];
    end

    assert_unqualified_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (addr == ADDR_W'(RI)) && !wdata[TOP]) |=> $stable(prio_q[k]));
  end

  always_comb begin
    pol_wr = wr_en && (addr == ADDR_W'(POL_ADDR));
    pol_d  = pol_wr ? wdata[N_EXT-1:0] : pol_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pol_q <= '1;
    else if (pol_wr) pol_q <= pol_d;
  end

  assign prio_o = prio_q;
  assign pol_o  = pol_q;
endmodule

// File: rtl/nibint_arb.sv
module nibint_arb
  import nibint_pkg::*;
#(
  parameter int N_SRC = NUM_SRC
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_SRC-1:0]              active_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0]  prio_i,
  output logic [PRIO_W-1:0]             lvl_o,
  output logic [SRC_W-1:0]              src_o
);
  logic [PRIO_W-1:0] win_lvl, lvl_q;
  logic [SRC_W-1:0]  win_idx, src_q;

  // strict compare keeps the lower index on a tie; level 0 can never win
  always_comb begin
    win_lvl = '0;
    win_idx = '0;
    for (int k = 0; k < N_SRC; k++) begin
      if (active_i[k] && (prio_i[k] > win_lvl)) begin
        win_lvl = prio_i[k];
        win_idx = SRC_W'(k);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      src_q <= '0;
    end else begin
      lvl_q <= win_lvl;
      src_q <= win_idx;
    end
  end

  assign lvl_o = lvl_q;
  assign src_o = src_q;

  assert_winner_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_lvl != '0) |-> (active_i[win_idx] && (prio_i[win_idx] == win_lvl)));

  for (genvar k = 0; k < N_SRC; k++) begin : g_chk
    assert_max_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i[k] && (prio_i[k] != '0)) |-> (win_lvl >= prio_i[k]));
  end
endmodule

// File: rtl/nibint_ctrl.sv
module nibint_ctrl
  import nibint_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  input  logic [NUM_SRC-1:0]   src_in,
  output logic [PRIO_W-1:0]    irq_level,
  output logic [SRC_W-1:0]     irq_src
);
  localparam int REG_IDX_W = $clog2(REGS);

  logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
  logic [NUM_SRC-1:0]             ack;
  logic [NUM_SRC-1:0]             status;
  logic [NUM_EXT-1:0]             pol;
  logic [REGS-1:0][DATA_W-1:0]    rd_regs;

  nibint_regs #(.N_SRC(NUM_SRC), .N_EXT(NUM_EXT)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .prio_o (prio),
    .ack_o  (ack),
    .pol_o  (pol)
  );

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    if (EDGE_MASK[k]) begin : g_edge
      localparam int J = ext_rank(32'(EDGE_MASK), k);
      nibint_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_i      (src_in[k]),
        .rise_sel_i (pol[J]),
        .ack_i      (ack[k]),
        .pending_o  (status[k])
      );
    end else begin : g_level
      assign status[k] = src_in[k];
    end
  end

  nibint_arb #(.N_SRC(NUM_SRC)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (status),
    .prio_i   (prio),
    .lvl_o    (irq_level),
    .src_o    (irq_src)
  );

  always_comb begin
    rd_regs = '0;
    for (int r = 0; r < REGS; r++) begin
      for (int f = 0; f < FIELDS; f++) begin
        if (r * FIELDS + f < NUM_SRC) begin
          rd_regs[r][DATA_W-1-FIELD_W*f -: FIELD_W] =
            {status[r*FIELDS+f], prio[r*FIELDS+f]};
        end
      end
    end
  end

  always_comb begin
    if (addr < ADDR_W'(REGS))
      rdata = rd_regs[addr[REG_IDX_W-1:0]];
    else if (addr == ADDR_W'(POL_ADDR))
      rdata = DATA_W'(pol);
    else
      rdata = '0;
  end
endmodule

// File: tb/test_nibint_ctrl.sv
`timescale 1ns/1ps
module test_nibint_ctrl;
  logic        clk, rst_n, wr_en;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  logic [27:0] src_in;
  logic [2:0]  irq_level;
  logic [4:0]  irq_src;
  int checks = 0;
  int errors = 0;

  nibint_ctrl i_nibint_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .src_in(src_in), .irq_level(irq_level), .irq_src(irq_src)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic chk_out(input string tag, input logic [2:0] lvl, input logic [4:0] src);
    chk({tag, " level"}, 32'(irq_level), 32'(lvl));
    chk({tag, " source"}, 32'(irq_src), 32'(src));
  endtask

  task automatic init_all();
    @(negedge clk);
    src_in = '0;
    wr(3'd4, 32'h3F);
    cycles(4);
    for (int r = 0; r < 4; r++) wr(3'(r), 32'h88888888);
    cycles(2);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int r = 0; r < 4; r++) begin
      rd(3'(r), d);
      chk("R1 control reg after reset", d, 32'h0);
    end
    rd(3'd4, d);
    chk("R1 polarity after reset", d, 32'h3F);
    chk_out("R1 reset outputs", 3'd0, 5'd0);
  endtask

  task automatic t_fields();
    logic [31:0] d;
    init_all();
    wr(3'd1, 32'h00000D00);                 // source 13 priority 5
    rd(3'd1, d);
    chk("R2 source 13 field position", d, 32'h00000500);
    @(negedge clk) src_in[13] = 1'b1;
    cycles(3);
    rd(3'd1, d);
    chk("R5 level source status bit", d, 32'h00000D00);
    chk_out("R2 source 13 wins", 3'd5, 5'd13);
    wr(3'd1, 32'h000007E0);                 // 13 unqualified, 14 prio 6
    rd(3'd1, d);
    chk("R3 unqualified field kept", d, 32'h00000D60);
    wr(3'd1, 32'h00000800);                 // mask 13
    cycles(3);
    rd(3'd1, d);
    chk("R4 masked field readback", d, 32'h00000860);
    chk_out("R4 masked source silent", 3'd0, 5'd0);
    wr(3'd3, 32'h0000FFFF);
    rd(3'd3, d);
    chk("R2 unused slots read zero", d, 32'h0);
  endtask

  task automatic t_arbitration();
    init_all();
    wr(3'd0, 32'h0000DD00);                 // sources 4,5 prio 5
    @(negedge clk) src_in[5] = 1'b1;
    #1 chk_out("R9 output still registered", 3'd0, 5'd0);
    @(negedge clk);
    chk_out("R9 one clock latency", 3'd5, 5'd5);
    @(negedge clk) src_in[4] = 1'b1;
    cycles(2);
    chk_out("R9 tie to lower index", 3'd5, 5'd4);
    wr(3'd1, 32'h0E000000);                 // source 9 prio 6
    @(negedge clk) src_in[9] = 1'b1;
    cycles(2);
    chk_out("R9 higher level wins", 3'd6, 5'd9);
    @(negedge clk) src_in[9] = 1'b0;
    cycles(2);
    chk_out("R10 level drop releases", 3'd5, 5'd4);
    @(negedge clk) src_in[4] = 1'b0;
    cycles(2);
    chk_out("R10 second drop", 3'd5, 5'd5);
  endtask

  task automatic t_edge_ack();
    logic [31:0] d;
    init_all();
    wr(3'd0, 32'hB0000000);                 // source 0 prio 3
    @(negedge clk) src_in[0] = 1'b1;
    cycles(6);
    chk_out("R5 rising edge pending", 3'd3, 5'd0);
    @(negedge clk) src_in[0] = 1'b0;
    cycles(6);
    rd(3'd0, d);
    chk("R5 pending held after pin low", d, 32'hB0000000);
    wr(3'd0, 32'hB0000000);                 // acknowledge, same prio
    cycles(2);
    rd(3'd0, d);
    chk("R7 ack clears keeps prio", d, 32'h30000000);
    chk_out("R7 ack clears request", 3'd0, 5'd0);
    @(negedge clk) src_in[0] = 1'b1;
    cycles(6);
    wr(3'd0, 32'h80000000);                 // mask + ack
    wr(3'd0, 32'hB0000000);
    cycles(2);
    chk_out("R7 mask write discards edge", 3'd0, 5'd0);
  endtask

  task automatic t_polarity();
    logic [31:0] d;
    init_all();
    wr(3'd4, 32'h0000002F);                 // source 25 falling
    wr(3'd3, 32'h0F000000);                 // source 25 prio 7
    @(negedge clk) src_in[25] = 1'b1;
    cycles(6);
    chk_out("R6 rising ignored on falling select", 3'd0, 5'd0);
    @(negedge clk) src_in[25] = 1'b0;
    cycles(6);
    chk_out("R6 falling edge detected", 3'd7, 5'd25);
    rd(3'd3, d);
    chk("R6 pending readback", d, 32'h0F000000);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    init_all();
    @(negedge clk) src_in[26] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd3; wdata = 32'h00A00000;  // prio 2 + ack
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    cycles(2);
    rd(3'd3, d);
    chk("R8 edge survives same-cycle ack", d, 32'h00A00000);
    chk_out("R8 collision output", 3'd2, 5'd26);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; src_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fields();
    t_arbitration();
    t_edge_ack();
    t_polarity();
    t_collision();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule